// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block takes an external interrupt request that arrives as a binary-coded priority level and turns it into per-source assert and deassert controls for a group of level-sensitive interrupt sources. A level of zero means that no request is present. Level one is the weakest request and the all-ones level is the strongest. The group has one member for each nonzero level, so a 4-bit level serves 15 members.

The level is captured in a register. The decoder does nothing until that captured value changes. When it changes, the decoder selects one member by inverting every bit of the level. The selected member is asserted if it is not already asserted, and its enable contribution is forced on if it was off. Every other member that is still asserted is deasserted in the same step. A level of zero inverts to an index one past the last member, so nothing is selected and the whole group is cleared.

The member assert states and the forced enables go to a downstream pending aggregator. Priority resolution among pending sources happens elsewhere.

Top module: `irl_level_decoder`

## Requirements
- R1: After reset, `src_assert`, `src_enable`, `src_set` and `src_clr` are all zero.
- R2: For a captured level L from 1 to 2^LVL_W-1, the selected member has index L XOR (2^LVL_W-1). One edge after the capture, `src_assert` is one-hot at that index.
- R3: A captured level of 0 leaves `src_assert` all zero one edge after the capture.
- R4: At most one bit of `src_assert` is ever set.
- R5: A member's `src_enable` bit becomes 1 on the edge that applies that member's selection. It then stays 1 until reset.
- R6: In the cycle after a changed level is captured, `src_set` is high for one cycle at the selected index, and only if that member was not asserted. In the same cycle, `src_clr` is high for one cycle at every other member that is asserted. `src_set` and `src_clr` are never high at the same bit.
- R7: While the captured level does not change, `src_set` and `src_clr` stay zero and `src_assert` and `src_enable` hold their values.
- R8: The level input is sampled on every rising clock edge. A level applied before edge k produces its pulses between edge k and edge k+1, and its new state after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_in | input | LVL_W | Encoded request level; 0 means no request |
| src_assert | output | 2^LVL_W-1 | Assert state of each group member |
| src_enable | output | 2^LVL_W-1 | Forced enable contribution of each member; once set it stays set until reset |
| src_set | output | 2^LVL_W-1 | One-cycle pulse when a member is being asserted |
| src_clr | output | 2^LVL_W-1 | One-cycle pulse when a member is being deasserted |

## Verification
The bench builds two copies of the block. One uses LVL_W=4 (15 members) and the other uses LVL_W=2 (3 members).

On both copies it drives every ordered pair of levels, including repeats. This covers every transition from one selected member to another, every move to and from level zero, and every case where the level is held. The 2-bit copy shows that the inverted-index rule and the out-of-range zero level follow the parameter, rather than being tied to 15 members.

// File: rtl/irl_pkg.sv
package irl_pkg;

  // Number of group members served by a level of the given width.
  function automatic int unsigned member_total(int unsigned lvl_w);
    return (32'd1 << lvl_w) - 32'd1;
  endfunction

  // Member index chosen by a level: all level bits inverted.
  // A zero level gives member_total(), which is one past the last member.
  function automatic int unsigned level_to_member(int unsigned lvl, int unsigned lvl_w);
    return lvl ^ member_total(lvl_w);
  endfunction

endpackage

// File: rtl/irl_level_capture.sv
module irl_level_capture #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_in,
  output logic [LVL_W-1:0] lvl_q,
  output logic             chg
);

  logic [LVL_W-1:0] lvl_seen;

  // Capture register for the incoming level.
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end

  // The level most recently acted on; updated in the cycle that acts on it.
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_seen <= '0;
    else        lvl_seen <= lvl_q;
  end

  assign chg = (lvl_q != lvl_seen);

endmodule

// File: rtl/irl_member_select.sv
module irl_member_select #(
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned MEMBERS = 15
) (
  input  logic [LVL_W-1:0]   lvl_q,
  output logic [MEMBERS-1:0] sel_oh
);

  logic [LVL_W-1:0] sel_idx;

  assign sel_idx = LVL_W'(irl_pkg::level_to_member(32'(lvl_q), LVL_W));

  // One compare per member. The out-of-range index from level 0 matches none.
  for (genvar i = 0; i < MEMBERS; i++) begin : g_cmp
    assign sel_oh[i] = (sel_idx == LVL_W'(i));
  end

endmodule

// File: rtl/irl_member_state.sv
module irl_member_state #(
  parameter int unsigned MEMBERS = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg,
  input  logic [MEMBERS-1:0] sel_oh,
  output logic [MEMBERS-1:0] src_assert,
  output logic [MEMBERS-1:0] src_enable,
  output logic [MEMBERS-1:0] src_set,
  output logic [MEMBERS-1:0] src_clr
);

  for (genvar i = 0; i < MEMBERS; i++) begin : g_mbr
    logic act_q;
    logic en_q;

    assign src_set[i] = chg &  sel_oh[i] & ~act_q;
    assign src_clr[i] = chg & ~sel_oh[i] &  act_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        en_q  <= 1'b0;
      end else begin
        if (src_set[i])              act_q <= 1'b1;
        else if (src_clr[i])         act_q <= 1'b0;
        if (chg && sel_oh[i] && !en_q) en_q <= 1'b1;
      end
    end

    assign src_assert[i] = act_q;
    assign src_enable[i] = en_q;
  end

endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder #(
  parameter int unsigned LVL_W = 4,
  localparam int unsigned MEMBERS = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   lvl_in,
  output logic [MEMBERS-1:0] src_assert,
  output logic [MEMBERS-1:0] src_enable,
  output logic [MEMBERS-1:0] src_set,
  output logic [MEMBERS-1:0] src_clr
);

  // Named internal events, used by the bound checker.
  logic [LVL_W-1:0]   lvl_q;
  logic               chg;
  logic [MEMBERS-1:0] sel_oh;

  irl_level_capture #(.LVL_W(LVL_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (lvl_in),
    .lvl_q  (lvl_q),
    .chg    (chg)
  );

  irl_member_select #(.LVL_W(LVL_W), .MEMBERS(MEMBERS)) u_select (
    .lvl_q  (lvl_q),
    .sel_oh (sel_oh)
  );

  irl_member_state #(.MEMBERS(MEMBERS)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg        (chg),
    .sel_oh     (sel_oh),
    .src_assert (src_assert),
    .src_enable (src_enable),
    .src_set    (src_set),
    .src_clr    (src_clr)
  );

endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk #(
  parameter int unsigned LVL_W = 4,
  localparam int unsigned MEMBERS = (1 << LVL_W) - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   lvl_q,
  input logic               chg,
  input logic [MEMBERS-1:0] src_assert,
  input logic [MEMBERS-1:0] src_enable,
  input logic [MEMBERS-1:0] src_set,
  input logic [MEMBERS-1:0] src_clr
);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_assert));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> (src_assert == $past(src_set)));

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && lvl_q == '0) |=> (src_assert == '0));

  p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(src_enable) & ~src_enable) == '0));

  p_set_clr_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set & src_clr) == '0);

  p_clr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr != '0) |=> ((src_assert & $past(src_clr)) == '0));

  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |=> ($stable(src_assert) && $stable(src_enable)));

  p_quiet_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> (src_set == '0 && src_clr == '0));

endmodule

bind irl_level_decoder irl_level_decoder_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_q      (lvl_q),
  .chg        (chg),
  .src_assert (src_assert),
  .src_enable (src_enable),
  .src_set    (src_set),
  .src_clr    (src_clr)
);

// File: tb/test_irl_level_decoder.sv
module test_irl_level_decoder;

  localparam int W4 = 4;
  localparam int N4 = 15;
  localparam int W2 = 2;
  localparam int N2 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W4-1:0] lvl4 = '0;
  logic [N4-1:0] a4, e4, s4, c4;
  logic [W2-1:0] lvl2 = '0;
  logic [N2-1:0] a2, e2, s2, c2;

  irl_level_decoder #(.LVL_W(W4)) i_irl_level_decoder (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl4),
    .src_assert(a4), .src_enable(e4), .src_set(s4), .src_clr(c4));

  irl_level_decoder #(.LVL_W(W2)) i_irl_level_decoder_w2 (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl2),
    .src_assert(a2), .src_enable(e2), .src_set(s2), .src_clr(c2));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench model: member index is (members - level); level 0 selects nothing.
  logic [31:0] m4_act = 0, m4_en = 0, m4_lvl = 0;
  logic [31:0] m2_act = 0, m2_en = 0, m2_lvl = 0;

  task automatic step4(int lvl);
    logic [31:0] sel, xs, xc;
    bit changed;
    changed = (lvl != m4_lvl);
    sel = (lvl == 0) ? 32'd0 : (32'd1 << (N4 - lvl));
    xs = changed ? (sel & ~m4_act) : 32'd0;
    xc = changed ? (m4_act & ~sel) : 32'd0;
    @(negedge clk) lvl4 = W4'(lvl);
    @(posedge clk); #2;
    chk(32'(s4) == xs, changed ? "R6" : "R7", "set pulse w4", 32'(s4), xs);
    chk(32'(c4) == xc, changed ? "R6" : "R7", "clr pulse w4", 32'(c4), xc);
    if (changed) begin
      m4_act = sel;
      m4_en  = m4_en | sel;
      m4_lvl = lvl;
    end
    @(posedge clk); #2;
    chk(32'(a4) == m4_act, (lvl == 0) ? "R3" : "R2", "assert w4", 32'(a4), m4_act);
    chk(32'(e4) == m4_en, "R5", "enable w4", 32'(e4), m4_en);
    chk(s4 == '0 && c4 == '0, "R8", "pulses end w4", {s4, c4}, 32'd0);
  endtask

  task automatic step2(int lvl);
    logic [31:0] sel, xs, xc;
    bit changed;
    changed = (lvl != m2_lvl);
    sel = (lvl == 0) ? 32'd0 : (32'd1 << (N2 - lvl));
    xs = changed ? (sel & ~m2_act) : 32'd0;
    xc = changed ? (m2_act & ~sel) : 32'd0;
    @(negedge clk) lvl2 = W2'(lvl);
    @(posedge clk); #2;
    chk(32'(s2) == xs, changed ? "R6" : "R7", "set pulse w2", 32'(s2), xs);
    chk(32'(c2) == xc, changed ? "R6" : "R7", "clr pulse w2", 32'(c2), xc);
    if (changed) begin
      m2_act = sel;
      m2_en  = m2_en | sel;
      m2_lvl = lvl;
    end
    @(posedge clk); #2;
    chk(32'(a2) == m2_act, (lvl == 0) ? "R3" : "R2", "assert w2", 32'(a2), m2_act);
    chk(32'(e2) == m2_en, "R5", "enable w2", 32'(e2), m2_en);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(a4 == '0 && e4 == '0, "R1", "reset state w4", {a4, e4}, 32'd0);
    chk(s4 == '0 && c4 == '0, "R1", "reset pulses w4", {s4, c4}, 32'd0);
    chk(a2 == '0 && e2 == '0 && s2 == '0 && c2 == '0, "R1", "reset w2",
        {a2, e2, s2, c2}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // Level held at zero after reset: nothing happens (R7)
    step4(0);

    // Every ordered pair of levels, including repeats (R2, R3, R5, R6, R7)
    for (int a = 0; a <= N4; a++) begin
      for (int b = 0; b <= N4; b++) begin
        step4(a);
        step4(b);
      end
    end
    // Held level keeps state and enables (R7)
    step4(7);
    step4(7);
    step4(7);

    for (int a = 0; a <= N2; a++) begin
      for (int b = 0; b <= N2; b++) begin
        step2(a);
        step2(b);
      end
    end

    // Reset clears the sticky enables (R1, R5)
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #2;
    chk(e4 == '0 && a4 == '0, "R1", "reset after use w4", {a4, e4}, 32'd0);
    chk(e2 == '0 && a2 == '0, "R1", "reset after use w2", {a2, e2}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule